// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This controller-side block loads the two mode registers of a DDR SDRAM device. A single start pulse captures the requested burst length code, burst ordering, read latency code, a DLL-reset request and a raw extended-register value. The block then writes the extended register first and the base mode register second. Each write is one command cycle on the DDR command and address pins.

Before each write the block waits until the memory reports that all banks are precharged and that clock enable is high. After each write it keeps the bus quiet for a fixed settle time. It never loads an unsupported latency or burst length code into the device. Such a request is refused at once with an error pulse, and no command is sent.

Top module: `ddr_mrs_seq`

## Requirements
- R1: While reset is asserted and directly after it, the pins show NOP (cs_n 0, ras_n/cas_n/we_n 1), ba_o and addr_o are zero, and busy_o, done_o and error_o are low.
- R2: An accepted request produces exactly two register-write commands (cs_n, ras_n, cas_n and we_n all 0). The first has ba_o = 01 and addr_o equal to the captured extended value. The second has ba_o = 00.
- R3: The base write carries addr_o[2:0] = burst length code, addr_o[3] = burst type (0 sequential, 1 interleaved), addr_o[6:4] = latency code, addr_o[7] = 0, addr_o[8] = DLL-reset request and addr_o[11:9] = 0.
- R4: A write command appears only in the cycle after an edge at which banks_idle_i and cke_i were both sampled high. Otherwise the block holds NOP and waits.
- R5: After every write command, at least SETTLE_CYC NOP cycles follow before the next command.
- R6: Legal burst length codes are 001, 010 and 011. Legal latency codes are 010, 011 and 110. A start request with any other code raises error_o for exactly one cycle, leaves busy_o low and issues no command.
- R7: Request fields are captured on the accepting edge. Changes to them, and start pulses, while busy_o is high have no effect on the commands.
- R8: busy_o rises in the cycle after an accepted start. done_o pulses for one cycle, SETTLE_CYC cycles after the base write cycle, and busy_o falls in the same cycle.
- R9: ba_o[1] is always 0, and every cycle that is not a write command is a NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run a programming sequence |
| burst_len_i | input | 3 | Burst length code |
| burst_type_i | input | 1 | Burst ordering, 1 = interleaved |
| cas_lat_i | input | 3 | Read latency code |
| dll_reset_i | input | 1 | Request a DLL reset in the base write |
| ext_mode_i | input | ADDR_W | Value for the extended register |
| banks_idle_i | input | 1 | All banks are precharged |
| cke_i | input | 1 | Clock enable to the device is high |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address, selects the register |
| addr_o | output | ADDR_W | Address bus, register contents |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence completes |
| error_o | output | 1 | One-cycle pulse on a reserved code |

## Verification
The bench covers every reserved burst and latency code. A design that let one through would show a write command or a busy cycle where only an error pulse is expected. It drops banks_idle_i before the first write and cke_i between the two writes. A design that ignored the preconditions would issue a command early, and the command count would be wrong. It also changes the request fields and pulses start in the middle of a sequence. A design that re-latched its inputs would write the new values or run a third write. Every command's gap from the one before, and the timing of done_o, are measured. A short settle time or a late or early done would show up there.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_EXT,
    S_SETTLE_EXT,
    S_WAIT_BASE,
    S_SETTLE_BASE
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam ddr_cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  localparam logic [1:0] BANK_BASE = 2'b00;
  localparam logic [1:0] BANK_EXT  = 2'b01;

endpackage

// File: rtl/mrs_code_check.sv
module mrs_code_check (
  input  logic [2:0] burst_len_i,
  input  logic [2:0] cas_lat_i,
  output logic       ok_o
);
  logic bl_ok, cl_ok;

  always_comb begin
    bl_ok = burst_len_i inside {3'b001, 3'b010, 3'b011};
    cl_ok = cas_lat_i inside {3'b010, 3'b011, 3'b110};
    ok_o  = bl_ok & cl_ok;
  end
endmodule

// File: rtl/mrs_word_build.sv
module mrs_word_build #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              dll_reset_i,
  output logic [ADDR_W-1:0] word_o
);
  // test-mode bit fixed low
  assign word_o[8:0] = {dll_reset_i, 1'b0, cas_lat_i, burst_type_i, burst_len_i};

  generate
    if (ADDR_W > 9) begin : g_pad
      assign word_o[ADDR_W-1:9] = '0;
    end
  endgenerate
endmodule

// File: rtl/mrs_settle_timer.sv
module mrs_settle_timer #(
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(SETTLE_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/ddr_mrs_seq.sv
module ddr_mrs_seq
  import ddr_mrs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              dll_reset_i,
  input  logic [ADDR_W-1:0] ext_mode_i,
  input  logic              banks_idle_i,
  input  logic              cke_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);
  seq_state_e        state_q;
  ddr_cmd_t          cmd_q;
  logic [1:0]        ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, err_q;

  logic [2:0]        bl_q, cl_q;
  logic              bt_q, dll_q;
  logic [ADDR_W-1:0] ext_q;

  logic              codes_ok, pre_ok, settle_last;
  logic              issue_ext, issue_base;
  logic [ADDR_W-1:0] base_word;

  mrs_code_check i_check (
    .burst_len_i (burst_len_i),
    .cas_lat_i   (cas_lat_i),
    .ok_o        (codes_ok)
  );

  mrs_word_build #(.ADDR_W(ADDR_W)) i_word (
    .burst_len_i  (bl_q),
    .burst_type_i (bt_q),
    .cas_lat_i    (cl_q),
    .dll_reset_i  (dll_q),
    .word_o       (base_word)
  );

  mrs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (issue_ext | issue_base),
    .last_o (settle_last)
  );

  assign pre_ok     = banks_idle_i & cke_i;
  assign issue_ext  = (state_q == S_WAIT_EXT)  & pre_ok;
  assign issue_base = (state_q == S_WAIT_BASE) & pre_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cmd_q   <= CMD_NOP;
      ba_q    <= BANK_BASE;
      addr_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      bl_q    <= '0;
      cl_q    <= '0;
      bt_q    <= 1'b0;
      dll_q   <= 1'b0;
      ext_q   <= '0;
    end else begin
      cmd_q  <= CMD_NOP;
      ba_q   <= BANK_BASE;
      addr_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            if (codes_ok) begin
              bl_q    <= burst_len_i;
              cl_q    <= cas_lat_i;
              bt_q    <= burst_type_i;
              dll_q   <= dll_reset_i;
              ext_q   <= ext_mode_i;
              state_q <= S_WAIT_EXT;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        S_WAIT_EXT: begin
          if (issue_ext) begin
            cmd_q   <= CMD_MRS;
            ba_q    <= BANK_EXT;
            addr_q  <= ext_q;
            state_q <= S_SETTLE_EXT;
          end
        end
        S_SETTLE_EXT: if (settle_last) state_q <= S_WAIT_BASE;
        S_WAIT_BASE: begin
          if (issue_base) begin
            cmd_q   <= CMD_MRS;
            ba_q    <= BANK_BASE;
            addr_q  <= base_word;
            state_q <= S_SETTLE_BASE;
          end
        end
        S_SETTLE_BASE: begin
          if (settle_last) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cs_n_o  = cmd_q.cs_n;
  assign ras_n_o = cmd_q.ras_n;
  assign cas_n_o = cmd_q.cas_n;
  assign we_n_o  = cmd_q.we_n;
  assign ba_o    = ba_q;
  assign addr_o  = addr_q;
  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;
endmodule

// File: rtl/ddr_mrs_seq_chk.sv
module ddr_mrs_seq_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned SETTLE_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              banks_idle_i,
  input logic              cke_i,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o
);
  logic        is_mrs, is_nop, ext_seen;
  int unsigned gap;

  assign is_mrs = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0000);
  assign is_nop = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap      <= SETTLE_CYC;
      ext_seen <= 1'b0;
    end else begin
      if (is_mrs)                 gap <= 0;
      else if (gap < SETTLE_CYC)  gap <= gap + 1;
      if (is_mrs && ba_o == 2'b01) ext_seen <= 1'b1;
      else if (done_o)             ext_seen <= 1'b0;
    end
  end

  a_r9_nop_or_mrs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_nop || is_mrs);
  a_r9_ba1_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ba_o[1]);
  a_r4_pre_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> $past(banks_idle_i && cke_i));
  a_r5_settle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> gap >= SETTLE_CYC);
  a_r2_ext_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && ba_o == 2'b00) |-> ext_seen);
  a_r3_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && ba_o == 2'b00) |-> (!addr_o[7] && ((addr_o >> 9) == '0)));
  a_r6_legal_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && ba_o == 2'b00) |->
      (addr_o[2:0] inside {3'b001, 3'b010, 3'b011}) &&
      (addr_o[6:4] inside {3'b010, 3'b011, 3'b110}));
  a_r6_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!busy_o && is_nop));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && ext_seen));
endmodule

bind ddr_mrs_seq ddr_mrs_seq_chk #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .banks_idle_i (banks_idle_i),
  .cke_i        (cke_i),
  .cs_n_o       (cs_n_o),
  .ras_n_o      (ras_n_o),
  .cas_n_o      (cas_n_o),
  .we_n_o       (we_n_o),
  .ba_o         (ba_o),
  .addr_o       (addr_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .error_o      (error_o)
);

// File: tb/test_ddr_mrs_seq.sv
`timescale 1ns/1ps
module test_ddr_mrs_seq;
  localparam int ADDR_W = 12;
  localparam int SETTLE = 2;

  typedef struct {
    logic [1:0]        ba;
    logic [ADDR_W-1:0] addr;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, bt, dll, banks_idle, cke;
  logic [2:0] bl, cl;
  logic [ADDR_W-1:0] ext;
  logic cs_n, ras_n, cas_n, we_n, busy, done, err;
  logic [1:0] ba;
  logic [ADDR_W-1:0] addr;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_cmd = -1000, cmd_seen = 0, err_seen = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  ddr_mrs_seq #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE)) i_ddr_mrs_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .burst_len_i(bl),
    .burst_type_i(bt), .cas_lat_i(cl), .dll_reset_i(dll), .ext_mode_i(ext),
    .banks_idle_i(banks_idle), .cke_i(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .busy_o(busy),
    .done_o(done), .error_o(err)
  );

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] base_word(input logic [2:0] b_l, input logic b_t,
                                                  input logic [2:0] c_l, input logic d);
    base_word = '0;
    base_word[2:0] = b_l;
    base_word[3]   = b_t;
    base_word[6:4] = c_l;
    base_word[8]   = d;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (err) err_seen++;
      if ({cs_n, ras_n, cas_n, we_n} == 4'b0000) begin
        cmd_seen++;
        chk(cyc - last_cmd >= SETTLE + 1, "R5 command spacing", cyc - last_cmd, SETTLE + 1);
        last_cmd = cyc;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected command", {ba, addr}, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(ba == e.ba, "R2 bank select", ba, e.ba);
          chk(addr == e.addr, "R3 R7 register value", addr, e.addr);
        end
      end
      if (done) begin
        chk(cyc - last_cmd == SETTLE, "R8 done timing", cyc - last_cmd, SETTLE);
        chk(!busy, "R8 busy falls with done", busy, 0);
      end
    end
  end

  task automatic start_cfg(input logic [2:0] b_l, input logic b_t, input logic [2:0] c_l,
                           input logic d, input logic [ADDR_W-1:0] x, input bit push);
    bl = b_l; bt = b_t; cl = c_l; dll = d; ext = x;
    if (push) begin
      exp_q.push_back('{ba: 2'b01, addr: x});
      exp_q.push_back('{ba: 2'b00, addr: base_word(b_l, b_t, c_l, d)});
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R8 busy after start", busy, 1);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done, "R8 done seen", done, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic bad_req(input logic [2:0] b_l, input logic [2:0] c_l);
    int prev;
    prev = cmd_seen;
    bl = b_l; cl = c_l; bt = 1'b0; dll = 1'b0; ext = '1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err, "R6 error pulse", err, 1);
    chk(!busy, "R6 stays idle", busy, 0);
    @(negedge clk);
    chk(!err, "R6 error one cycle", err, 0);
    repeat (4) @(negedge clk);
    chk(cmd_seen == prev, "R6 no command", cmd_seen, prev);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int prev;
    start = 0; bl = 0; bt = 0; cl = 0; dll = 0; ext = '0; banks_idle = 1; cke = 1;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 NOP in reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(ba == 0 && addr == 0, "R1 bus zero", {ba, addr}, 0);
    chk({busy, done, err} == 0, "R1 flags low", {busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n, busy} == 5'b01110, "R1 after reset", {cs_n, ras_n, cas_n, we_n, busy}, 5'b01110);

    // R2 R3 several configurations
    start_cfg(3'b010, 1'b0, 3'b011, 1'b1, 12'h002, 1); wait_done();
    start_cfg(3'b011, 1'b1, 3'b110, 1'b0, 12'h040, 1); wait_done();
    start_cfg(3'b001, 1'b1, 3'b010, 1'b1, 12'h000, 1); wait_done();
    chk(cmd_seen == 6, "R2 two writes per request", cmd_seen, 6);

    // R6 reserved codes
    bad_req(3'b000, 3'b011);
    bad_req(3'b100, 3'b010);
    bad_req(3'b111, 3'b110);
    bad_req(3'b010, 3'b000);
    bad_req(3'b011, 3'b111);
    bad_req(3'b001, 3'b101);
    bad_req(3'b010, 3'b001);
    bad_req(3'b011, 3'b100);

    // R4 banks not idle before first write
    banks_idle = 1'b0;
    prev = cmd_seen;
    start_cfg(3'b010, 1'b1, 3'b011, 1'b0, 12'h3C1, 0);
    repeat (6) @(negedge clk);
    chk(cmd_seen == prev, "R4 wait for idle banks", cmd_seen, prev);
    chk(busy, "R8 busy while waiting", busy, 1);
    exp_q.push_back('{ba: 2'b01, addr: 12'h3C1});
    exp_q.push_back('{ba: 2'b00, addr: base_word(3'b010, 1'b1, 3'b011, 1'b0)});
    banks_idle = 1'b1;
    wait_done();

    // R4 clock enable low between the writes
    prev = cmd_seen;
    start_cfg(3'b011, 1'b0, 3'b110, 1'b1, 12'h0A5, 1);
    for (int i = 0; i < 50; i++) begin
      @(posedge clk); #1;
      if ({cs_n, ras_n, cas_n, we_n} == 4'b0000) break;
    end
    cke = 1'b0;
    repeat (6) @(negedge clk);
    chk(cmd_seen == prev + 1, "R4 wait for clock enable", cmd_seen, prev + 1);
    cke = 1'b1;
    wait_done();

    // R7 restart and field changes while busy
    prev = cmd_seen;
    start_cfg(3'b011, 1'b0, 3'b010, 1'b0, 12'h1A5, 1);
    bl = 3'b111; cl = 3'b011; bt = 1'b1; dll = 1'b1; ext = 12'hFFF;
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (6) @(negedge clk);
    chk(cmd_seen == prev + 2, "R7 no extra writes", cmd_seen, prev + 2);
    chk(err_seen == 8, "R7 no error while busy", err_seen, 8);
    chk(!busy, "R7 idle afterwards", busy, 0);
    chk(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule